// File: doc/BRIEF.md
# Wake Interrupt Polarity Normalizer

This block sits in front of an interrupt controller that only understands rising-edge pulses and active-high levels. It accepts a vector of raw, asynchronous wake-capable pin inputs. Each pin has its own 32-bit configuration word that picks one trigger type. The block synchronizes each pin, applies inversion or edge detection, and drives a normalized request onto one line of an output vector. Edge-type pins produce a one-cycle high pulse. Level-type pins produce a high level for as long as the pin is active.

Which output line a pin drives comes from a region table fixed at elaboration. Each region gives a first pin, a first output and a count. A pin that no region covers has no output. Software reaches the configuration words, the enable storage and a fixed version word through a word-wide register port. Reads are combinational and writes take effect at the clock edge. The version parameter also selects where the enable bits live. At the newer layout each pin has an enable bit inside its own word. At the older layout the enables sit in a separate bank of packed words.

Top module: `wake_polarity_norm`

## Requirements
- R1: After reset every output is 0, and every configuration word and every enable-bank word reads 0.
- R2: When bit 1 of a pin's type field is 0, the pin is level sensitive. If bit 2 is 1 (codes 100 and 101), the output follows the synchronized input. If bit 2 is 0 (codes 000 and 001), the output is the synchronized input inverted.
- R3: When bit 1 of the type field is 1, the pin is edge sensitive. Code 110 pulses on a 0-to-1 input change, 010 on a 1-to-0 change, and 111 or 011 on either change. A change in the other direction produces nothing.
- R4: An input change appears on the output at the third rising clock edge after it is applied. An edge pulse stays high for exactly one cycle.
- R5: When VERSION is 0x30200 or higher, bit 3 of a pin's configuration word is that pin's enable. Writes to the enable bank are then ignored, and the bank reads 0.
- R6: When VERSION is below 0x30200, pin p is enabled by bit p%32 of the bank word at byte offset 0x10 + 4*(p/32). Bit 3 of the configuration word is then plain storage.
- R7: The configuration word of pin p is at byte offset 0x110 + 4*p and keeps all 32 written bits on read-back. Offset 0x1000 returns VERSION and ignores writes. Any other offset reads 0 and ignores writes.
- R8: A pin covered by a region drives output index out_base + pin - pin_base. When several regions cover the pin, the lowest-numbered region wins.
- R9: A pin that no region covers never asserts any output.
- R10: A write that changes a pin's type field forces that pin's output to 0 on the following cycle and discards any edge already detected in that cycle. Changing the type while the input is steady produces no pulse.
- R11: While a pin is disabled, its output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address for read and write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| pinIn | input | NUM_PINS | Raw asynchronous pin inputs |
| irqOut | output | NUM_OUTS | Normalized requests to the interrupt controller |

## Verification
The bench builds two copies side by side on the same pins, both with 64 pins, 96 outputs and three regions. One copy uses version 0x30200 and the other 0x30100, so both enable layouts are exercised in one run. The default regions overlap on pins 10 to 15, which exercises the first-region-wins rule. Pins 40 and above fall in no region. Region ends at pins 15/16 and 39/40 give boundary cases on both sides.

// File: rtl/wake_norm_pkg.sv
package wake_norm_pkg;

  // Per-pin control strobes handed from the register side to the datapath
  typedef struct packed {
    logic       en;     // pin enabled
    logic [2:0] kind;   // trigger type field
    logic       clr;    // type field is being changed this cycle
  } pinCtl_t;

  localparam logic [15:0] BANK_BASE = 16'h0010;
  localparam logic [15:0] CFG_BASE  = 16'h0110;
  localparam logic [15:0] VER_ADDR  = 16'h1000;
  localparam logic [31:0] PER_PIN_EN_VERSION = 32'h0003_0200;
  localparam int          EN_BIT    = 3;

endpackage

// File: rtl/wake_norm_ctrl.sv
module wake_norm_ctrl
  import wake_norm_pkg::*;
#(
  parameter int          NUM_PINS = 64,
  parameter int          ADDR_W   = 16,
  parameter logic [31:0] VERSION  = 32'h0003_0200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output pinCtl_t           pinCtl [NUM_PINS]
);

  localparam int  IDX_W      = ADDR_W - 2;
  localparam int  NUM_BANKS  = (NUM_PINS + 31) / 32;
  localparam bit  PER_PIN_EN = (VERSION >= PER_PIN_EN_VERSION);
  localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(CFG_BASE + 16'(4 * NUM_PINS));
  localparam logic [ADDR_W-1:0] VER_A  = ADDR_W'(VER_ADDR);

  logic [31:0]       cfgWord [NUM_PINS];
  logic [NUM_PINS-1:0] cfgWe;
  logic [NUM_PINS-1:0] pinEn;
  logic              cfgSel;
  logic              verSel;
  logic [ADDR_W-1:0] cfgOff;
  logic [IDX_W-1:0]  cfgIdx;
  logic [31:0]       bankRd;

  assign cfgSel = (regAddr[1:0] == 2'b00) && (regAddr >= CFG_LO) && (regAddr < CFG_HI);
  assign verSel = (regAddr == VER_A);
  assign cfgOff = regAddr - CFG_LO;
  assign cfgIdx = cfgOff[ADDR_W-1:2];

  // Configuration words, one per pin
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_cfg
    assign cfgWe[p] = regWrEn && cfgSel && (cfgIdx == IDX_W'(p));

    always_ff @(posedge clk) begin
      if (!rstN)          cfgWord[p] <= '0;
      else if (cfgWe[p])  cfgWord[p] <= regWrData;
    end

    always_comb begin
      pinCtl[p].en   = pinEn[p];
      pinCtl[p].kind = cfgWord[p][2:0];
      pinCtl[p].clr  = cfgWe[p] && (regWrData[2:0] != cfgWord[p][2:0]);
    end
  end

  // Enable location chosen by version
  if (PER_PIN_EN) begin : g_en_word
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign pinEn[p] = cfgWord[p][EN_BIT];
    end
    assign bankRd = '0;
  end else begin : g_en_bank
    localparam logic [ADDR_W-1:0] BANK_LO = ADDR_W'(BANK_BASE);
    localparam logic [ADDR_W-1:0] BANK_HI = ADDR_W'(BANK_BASE + 16'(4 * NUM_BANKS));
    logic [31:0]       bankWord [NUM_BANKS];
    logic              bankSel;
    logic [ADDR_W-1:0] bankOff;
    logic [IDX_W-1:0]  bankIdx;

    assign bankSel = (regAddr[1:0] == 2'b00) && (regAddr >= BANK_LO) && (regAddr < BANK_HI);
    assign bankOff = regAddr - BANK_LO;
    assign bankIdx = bankOff[ADDR_W-1:2];

    for (genvar w = 0; w < NUM_BANKS; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rstN)
          bankWord[w] <= '0;
        else if (regWrEn && bankSel && (bankIdx == IDX_W'(w)))
          bankWord[w] <= regWrData;
      end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign pinEn[p] = bankWord[p / 32][p % 32];
    end

    always_comb begin
      bankRd = '0;
      for (int w = 0; w < NUM_BANKS; w++)
        if (bankSel && (bankIdx == IDX_W'(w))) bankRd = bankWord[w];
    end
  end

  // Read mux
  always_comb begin
    regRdData = bankRd;
    if (verSel) regRdData = VERSION;
    for (int p = 0; p < NUM_PINS; p++)
      if (cfgSel && (cfgIdx == IDX_W'(p))) regRdData = cfgWord[p];
  end

endmodule

// File: rtl/wake_norm_datapath.sv
module wake_norm_datapath
  import wake_norm_pkg::*;
#(
  parameter int NUM_PINS = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  pinCtl_t             pinCtl [NUM_PINS],
  output logic [NUM_PINS-1:0] pinOut
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic syncA, syncB, prevB, hit;
    logic isEdge, highSense, dual;

    assign isEdge    = pinCtl[p].kind[1];
    assign highSense = pinCtl[p].kind[2];
    assign dual      = pinCtl[p].kind[0];

    // Normalize: inversion for low/falling, detection for edges
    always_comb begin
      if (!isEdge)        hit = highSense ? syncB : !syncB;
      else if (dual)      hit = syncB ^ prevB;
      else if (highSense) hit = syncB && !prevB;
      else                hit = !syncB && prevB;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncA     <= 1'b0;
        syncB     <= 1'b0;
        prevB     <= 1'b0;
        pinOut[p] <= 1'b0;
      end else begin
        syncA     <= pinIn[p];
        syncB     <= syncA;
        prevB     <= syncB;
        pinOut[p] <= pinCtl[p].en && !pinCtl[p].clr && hit;
      end
    end
  end

endmodule

// File: rtl/wake_norm_remap.sv
module wake_norm_remap #(
  parameter int NUM_PINS    = 64,
  parameter int NUM_OUTS    = 96,
  parameter int NUM_REGIONS = 3,
  parameter logic [NUM_REGIONS*32-1:0] REGION_PIN_BASE = '0,
  parameter logic [NUM_REGIONS*32-1:0] REGION_OUT_BASE = '0,
  parameter logic [NUM_REGIONS*32-1:0] REGION_COUNT    = '0
) (
  input  logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_OUTS-1:0] irqOut
);

  localparam int OUT_W = (NUM_OUTS > 1) ? $clog2(NUM_OUTS) : 1;

  // Walk regions from last to first so the lowest-numbered match is kept
  function automatic int lookup(int pin);
    int res, pb, ob, cnt;
    res = -1;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
      pb  = int'(REGION_PIN_BASE[r*32 +: 32]);
      ob  = int'(REGION_OUT_BASE[r*32 +: 32]);
      cnt = int'(REGION_COUNT[r*32 +: 32]);
      if (pin >= pb && pin < pb + cnt && (ob + pin - pb) < NUM_OUTS)
        res = ob + pin - pb;
    end
    return res;
  endfunction

  logic             pinValid [NUM_PINS];
  logic [OUT_W-1:0] pinIdx   [NUM_PINS];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_map
    localparam int IDX = lookup(p);
    assign pinValid[p] = (IDX >= 0);
    assign pinIdx[p]   = (IDX >= 0) ? OUT_W'(IDX) : '0;
  end

  always_comb begin
    irqOut = '0;
    for (int p = 0; p < NUM_PINS; p++)
      if (pinValid[p]) irqOut[pinIdx[p]] = irqOut[pinIdx[p]] | pinOut[p];
  end

endmodule

// File: rtl/wake_polarity_norm.sv
module wake_polarity_norm
  import wake_norm_pkg::*;
#(
  parameter int          NUM_PINS    = 64,
  parameter int          NUM_OUTS    = 96,
  parameter int          NUM_REGIONS = 3,
  parameter int          ADDR_W      = 16,
  parameter logic [31:0] VERSION     = 32'h0003_0200,
  parameter logic [NUM_REGIONS*32-1:0] REGION_PIN_BASE = {32'd10, 32'd16, 32'd0},
  parameter logic [NUM_REGIONS*32-1:0] REGION_OUT_BASE = {32'd60, 32'd10, 32'd40},
  parameter logic [NUM_REGIONS*32-1:0] REGION_COUNT    = {32'd30, 32'd20, 32'd16}
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_OUTS-1:0] irqOut
);

  pinCtl_t             pinCtl [NUM_PINS];
  logic [NUM_PINS-1:0] pinOut;

  wake_norm_ctrl #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .VERSION(VERSION)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pinCtl(pinCtl)
  );

  wake_norm_datapath #(
    .NUM_PINS(NUM_PINS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinCtl(pinCtl), .pinOut(pinOut)
  );

  wake_norm_remap #(
    .NUM_PINS(NUM_PINS), .NUM_OUTS(NUM_OUTS), .NUM_REGIONS(NUM_REGIONS),
    .REGION_PIN_BASE(REGION_PIN_BASE), .REGION_OUT_BASE(REGION_OUT_BASE),
    .REGION_COUNT(REGION_COUNT)
  ) u_remap (
    .pinOut(pinOut), .irqOut(irqOut)
  );

endmodule

// File: rtl/wake_polarity_norm_chk.sv
module wake_polarity_norm_chk
  import wake_norm_pkg::*;
#(
  parameter int          NUM_PINS = 64,
  parameter int          NUM_OUTS = 96,
  parameter int          ADDR_W   = 16,
  parameter logic [31:0] VERSION  = 32'h0003_0200
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [31:0]         regRdData,
  input logic [NUM_OUTS-1:0] irqOut,
  input pinCtl_t             pinCtl [NUM_PINS],
  input logic [NUM_PINS-1:0] pinOut
);

  // R1: the cycle after reset is held, nothing is requested
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (irqOut == '0));

  // R7: version offset always returns the elaboration value
  assert_version_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(VER_ADDR)) |-> (regRdData == VERSION));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    // R11: a disabled pin drives nothing on the next cycle
    assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
      !pinCtl[p].en |=> !pinOut[p]);

    // R10: a type change clears the pin's request
    assert_type_change_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
      pinCtl[p].clr |=> !pinOut[p]);

    // R4: single-direction edge pulses last one cycle
    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rstN)
      (pinOut[p] && pinCtl[p].kind[1] && !pinCtl[p].kind[0]) |=> !pinOut[p]);
  end

endmodule

bind wake_polarity_norm wake_polarity_norm_chk #(
  .NUM_PINS(NUM_PINS), .NUM_OUTS(NUM_OUTS), .ADDR_W(ADDR_W), .VERSION(VERSION)
) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdData(regRdData),
  .irqOut(irqOut), .pinCtl(pinCtl), .pinOut(pinOut)
);

// File: tb/sim_wake_polarity_norm.sv
module sim_wake_polarity_norm;

  localparam int NP = 64;
  localparam int NO = 96;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0] pinIn = '0;

  logic        wrEn0 = 0, wrEn1 = 0;
  logic [15:0] addr0 = '0, addr1 = '0;
  logic [31:0] wdat0 = '0, wdat1 = '0;
  logic [31:0] rdat0, rdat1;
  logic [NO-1:0] irq0, irq1;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  wake_polarity_norm #(.VERSION(32'h0003_0200)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(wrEn0), .regAddr(addr0),
    .regWrData(wdat0), .regRdData(rdat0), .pinIn(pinIn), .irqOut(irq0));

  wake_polarity_norm #(.VERSION(32'h0003_0100)) u1 (
    .clk(clk), .rstN(rstN), .regWrEn(wrEn1), .regAddr(addr1),
    .regWrData(wdat1), .regRdData(rdat1), .pinIn(pinIn), .irqOut(irq1));

  typedef struct packed {
    logic [7:0] pin;
    logic [2:0] kind;
    logic       startLv;
    logic       endLv;
    logic [7:0] outIdx;
    logic       exp1;
    logic       exp2;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'd3,  3'b110, 1'b0, 1'b1, 8'd43, 1'b1, 1'b0},  // R3 rising fires
    '{8'd3,  3'b010, 1'b1, 1'b0, 8'd43, 1'b1, 1'b0},  // R3 falling fires
    '{8'd20, 3'b010, 1'b0, 1'b1, 8'd14, 1'b0, 1'b0},  // R3 falling ignores rise
    '{8'd20, 3'b111, 1'b1, 1'b0, 8'd14, 1'b1, 1'b0},  // R3 dual on fall
    '{8'd20, 3'b111, 1'b0, 1'b1, 8'd14, 1'b1, 1'b0},  // R3 dual on rise
    '{8'd12, 3'b100, 1'b0, 1'b1, 8'd52, 1'b1, 1'b1},  // R2 R8 level high, first region wins
    '{8'd12, 3'b000, 1'b1, 1'b0, 8'd52, 1'b1, 1'b1},  // R2 level low inverted
    '{8'd37, 3'b000, 1'b0, 1'b1, 8'd87, 1'b0, 1'b0},  // R2 level low released
    '{8'd39, 3'b101, 1'b0, 1'b1, 8'd89, 1'b1, 1'b1},  // R2 R8 code 101 high, region end
    '{8'd30, 3'b110, 1'b1, 1'b0, 8'd24, 1'b0, 1'b0},  // R3 rising ignores fall
    '{8'd15, 3'b011, 1'b0, 1'b1, 8'd55, 1'b1, 1'b0},  // R3 R8 code 011 dual, region end
    '{8'd16, 3'b100, 1'b0, 1'b1, 8'd10, 1'b1, 1'b1}   // R8 next region start
  };

  task automatic chk(string req, logic [NO-1:0] act, logic [NO-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  task automatic wr(int sel, logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    if (sel == 0) begin wrEn0 = 1; addr0 = a; wdat0 = d; end
    else          begin wrEn1 = 1; addr1 = a; wdat1 = d; end
    @(negedge clk);
    wrEn0 = 0; wrEn1 = 0;
  endtask

  task automatic rd(int sel, logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    if (sel == 0) addr0 = a; else addr1 = a;
    #1;
    d = (sel == 0) ? rdat0 : rdat1;
  endtask

  function automatic logic [15:0] cfgA(int p);
    return 16'h0110 + 16'(4 * p);
  endfunction

  function automatic logic [NO-1:0] hot(logic v, int idx);
    return v ? (NO'(1) << idx) : '0;
  endfunction

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] r;
    waitN(4);
    rstN = 1;
    waitN(1);
    // R1 reset state
    chk("R1 outputs u0", irq0, '0);
    chk("R1 outputs u1", irq1, '0);
    rd(0, cfgA(3), r);  chk("R1 cfg word", NO'(r), '0);
    rd(1, 16'h0010, r); chk("R1 bank word", NO'(r), '0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      int p;
      p = int'(VECS[v].pin);
      pinIn[p] = VECS[v].startLv;
      waitN(4);
      wr(0, cfgA(p), {28'h0, 1'b1, VECS[v].kind});
      waitN(2);
      pinIn[p] = VECS[v].endLv;
      waitN(3);
      chk($sformatf("R4 vec%0d first", v), irq0, hot(VECS[v].exp1, int'(VECS[v].outIdx)));
      waitN(1);
      chk($sformatf("R4 vec%0d second", v), irq0, hot(VECS[v].exp2, int'(VECS[v].outIdx)));
      wr(0, cfgA(p), 32'h0);
      pinIn[p] = 1'b0;
      waitN(5);
    end

    // R9 unmapped pin never forwarded
    pinIn[40] = 1'b1;
    wr(0, cfgA(40), 32'h0000_000C);
    waitN(5);
    chk("R9 unmapped pin 40", irq0, '0);
    wr(0, cfgA(40), 32'h0);
    pinIn[40] = 1'b0;

    // R11 disabled level-high pin stays quiet; R5 bank ignored at new version
    wr(0, 16'h0010, 32'hFFFF_FFFF);
    rd(0, 16'h0010, r); chk("R5 bank reads 0", NO'(r), '0);
    pinIn[5] = 1'b1;
    wr(0, cfgA(5), 32'h0000_0004);
    waitN(5);
    chk("R11 R5 disabled pin 5", irq0, '0);
    wr(0, cfgA(5), 32'h0);
    pinIn[5] = 1'b0;

    // R7 read-back, version, unmapped offset
    wr(0, cfgA(7), 32'hABCD_12F0);
    rd(0, cfgA(7), r); chk("R7 cfg read-back", NO'(r), NO'(32'hABCD_12F0));
    wr(0, cfgA(7), 32'h0);
    rd(0, 16'h1000, r); chk("R7 version u0", NO'(r), NO'(32'h0003_0200));
    rd(1, 16'h1000, r); chk("R7 version u1", NO'(r), NO'(32'h0003_0100));
    wr(0, 16'h0800, 32'h1234_5678);
    rd(0, 16'h0800, r); chk("R7 unmapped offset", NO'(r), '0);

    // R6 older layout: bank enables
    pinIn[3] = 1'b1;
    pinIn[35] = 1'b1;
    wr(1, cfgA(3), 32'h0000_000C);
    wr(1, cfgA(35), 32'h0000_0004);
    waitN(5);
    chk("R6 cfg bit3 not an enable", irq1, '0);
    wr(1, 16'h0010, 32'h0000_0008);
    waitN(2);
    chk("R6 bank word0 bit3 enables pin 3", irq1, hot(1'b1, 43));
    wr(1, 16'h0014, 32'h0000_0008);
    waitN(2);
    chk("R6 bank word1 bit3 enables pin 35", irq1, hot(1'b1, 43) | hot(1'b1, 29));
    rd(1, 16'h0014, r); chk("R6 bank read-back", NO'(r), NO'(32'h8));
    wr(1, 16'h0010, 32'h0);
    wr(1, 16'h0014, 32'h0);
    pinIn[3] = 1'b0;
    pinIn[35] = 1'b0;
    waitN(4);

    // R10 steady input, type change gives no pulse
    pinIn[4] = 1'b1;
    waitN(4);
    wr(0, cfgA(4), 32'h0000_000E);
    waitN(3);
    wr(0, cfgA(4), 32'h0000_000A);
    chk("R10 steady change cycle 1", irq0, '0);
    waitN(1);
    chk("R10 steady change cycle 2", irq0, '0);
    wr(0, cfgA(4), 32'h0000_000E);
    chk("R10 steady change back", irq0, '0);
    waitN(1);
    chk("R10 steady change back 2", irq0, '0);

    // R10 in-flight edge discarded by a type change
    pinIn[4] = 1'b0;
    waitN(5);
    pinIn[4] = 1'b1;
    waitN(2);
    wrEn0 = 1; addr0 = cfgA(4); wdat0 = 32'h0000_000F;
    @(negedge clk);
    wrEn0 = 0;
    chk("R10 in-flight edge cleared", irq0, '0);
    waitN(1);
    chk("R10 no late pulse", irq0, '0);
    wr(0, cfgA(4), 32'h0);
    pinIn[4] = 1'b0;
    waitN(3);

    finishRun();
  end

endmodule